// File: doc/BRIEF.md
# DMA Request Boundary Splitter

This block sits between an internal DMA engine and the bus request path. The engine hands it one transfer at a time: a start byte address, a byte count of up to 65535 and a direction flag. The splitter turns the transfer into a series of bus request descriptors, each with an address, a length and a direction. It issues at most one descriptor per clock, under a valid/ready handshake. Every descriptor stays inside one 4 kB page. A write descriptor never exceeds the configured payload size and a read descriptor never exceeds the configured read request size. Both also respect a separate internal length cap.

Splitting is all-or-nothing. A transfer that meets every limit as one request goes out whole, even when it spans several cache lines. A transfer that cannot go out whole is cut only at cache line boundaries. Each non-final piece ends at the furthest line boundary that the limits and the current page allow. The configuration inputs are captured when a transfer is accepted. Changing them mid-transfer therefore has no effect on that transfer. A transfer of zero bytes is refused with a one-cycle error pulse and produces no requests.

Top module: `dma_req_splitter`

## Requirements
- R1: After reset, `out_valid` and `err_zero_len` are low and `in_ready` is high.
- R2: For every emitted request, `out_addr[11:0] + out_len` is at most 4096, so no request crosses a 4 kB aligned boundary.
- R3: A write request (`out_write`=1) has a length of at most 128 bytes when `cfg_mps_sel`=0 and at most 256 bytes when `cfg_mps_sel`=1.
- R4: A read request (`out_write`=0) has a length of at most `cfg_rd_max` bytes, for any nonzero `cfg_rd_max`. Values above 4096 act as 4096.
- R5: Every request has a length of at most `cfg_cap` bytes, for any nonzero `cfg_cap`. Values above 4096 act as 4096.
- R6: When the whole transfer is within the applicable limit and does not cross a 4 kB boundary, exactly one request carries it, with `out_last`=1 and the full length.
- R7: When a transfer needs two or more requests, every non-final request ends on a multiple of the cache line size. The line size is 16 << `cfg_line_code`, so codes 0..3 select 16, 32, 64 or 128 bytes. Each such request ends at the furthest line boundary within the limit and the current page. This holds whenever the effective limit is at least one line.
- R8: The requests of one transfer are contiguous, start at the transfer address, and cover exactly its byte count. Each carries the transfer direction. `out_last` is high on the final request only.
- R9: `in_ready` is low from the cycle after a nonzero transfer is accepted until the cycle after its final request is accepted. While `out_valid` is high and `out_ready` is low, the request outputs hold steady.
- R10: A transfer accepted with `in_len`=0 raises `err_zero_len` for exactly one cycle, the cycle after acceptance, and emits no request.
- R11: The configuration inputs are sampled at acceptance. Changes made to them during a transfer do not alter its requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transfer descriptor offered |
| in_ready | output | 1 | Splitter can take a transfer |
| in_addr | input | AW | Transfer start byte address |
| in_len | input | 16 | Transfer byte count |
| in_write | input | 1 | 1 = write, 0 = read |
| cfg_mps_sel | input | 1 | Payload size select: 0 = 128 B, 1 = 256 B |
| cfg_rd_max | input | 13 | Read request size limit in bytes |
| cfg_cap | input | 13 | Internal length cap in bytes |
| cfg_line_code | input | 2 | Cache line size code, line = 16 << code |
| out_valid | output | 1 | Request descriptor valid |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | AW | Request start byte address |
| out_len | output | 13 | Request byte count |
| out_write | output | 1 | Request direction |
| out_last | output | 1 | Final request of the transfer |
| err_zero_len | output | 1 | One-cycle pulse for a refused zero-length transfer |

## Verification
The bench goes after several corner cases, each with a distinct failure.
- Fits-whole transfers that straddle cache lines. A design that always cuts at lines would emit two requests where one is expected.
- Transfers that reach just past a 4 kB page. A design that ignores the page would emit one oversized request.
- A start address that is not line-aligned. The first piece must then end on a line boundary, and a design that cuts at the raw limit would leave later pieces misaligned.
- A maximum-length read across sixteen pages, to exercise length accumulation and the last flag.
- A zero-length transfer. It must pulse the error and stay silent, not emit an empty request.
- A configuration change right after acceptance. A design that reads the live inputs would change the piece lengths.
- Downstream stalls. A design that advances without the handshake would skip or repeat pieces.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  localparam int PAGE_BITS  = 12;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int LIM_W      = PAGE_BITS + 1;
  localparam int XLEN_W     = 16;
  localparam int LINE_CODES = 4;
  localparam int LINE_MIN   = 16;

  typedef logic [LIM_W-1:0]     lim_t;
  typedef logic [PAGE_BITS-1:0] pmask_t;

  typedef struct packed {
    lim_t   limit;
    pmask_t line_mask;
    logic   write;
  } xfer_cfg_t;

  function automatic lim_t lim_min(input lim_t a, input lim_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic lim_t payload_bytes(input logic sel);
    return sel ? lim_t'(256) : lim_t'(128);
  endfunction

  // Effective per-request limit: direction limit, then the internal cap,
  // clamped to one page and kept nonzero so the walk always advances.
  function automatic lim_t pick_limit(input logic write, input logic mps_sel,
                                      input lim_t rd_max, input lim_t cap);
    lim_t d;
    lim_t m;
    d = write ? payload_bytes(mps_sel) : rd_max;
    m = lim_min(d, cap);
    if (m > lim_t'(PAGE_BYTES)) m = lim_t'(PAGE_BYTES);
    if (m == '0) m = lim_t'(1);
    return m;
  endfunction

endpackage

// File: rtl/dma_split_cfg_latch.sv
module dma_split_cfg_latch
  import dma_split_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                write,
  input  logic                mps_sel,
  input  lim_t                rd_max,
  input  lim_t                cap,
  input  logic [1:0]          line_code,
  output xfer_cfg_t           cfg_q
);

  pmask_t mask_tbl [LINE_CODES];

  for (genvar g = 0; g < LINE_CODES; g++) begin : g_line
    assign mask_tbl[g] = pmask_t'((LINE_MIN << g) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (capture) begin
      cfg_q.limit     <= pick_limit(write, mps_sel, rd_max, cap);
      cfg_q.line_mask <= mask_tbl[line_code];
      cfg_q.write     <= write;
    end
  end

endmodule

// File: rtl/dma_split_chunk_calc.sv
module dma_split_chunk_calc
  import dma_split_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW:0] cur,
  input  logic [AW:0] tot_end,
  input  xfer_cfg_t   cfg,
  output logic [AW:0] nxt_end,
  output lim_t        chunk_len,
  output logic        chunk_last
);

  localparam int XW = AW + 1;

  function automatic logic [AW:0] page_end(input logic [AW:0] a);
    logic [AW:0] base;
    base = a & ~XW'(PAGE_BYTES - 1);
    return base + XW'(PAGE_BYTES);
  endfunction

  function automatic logic [AW:0] xmin(input logic [AW:0] a, input logic [AW:0] b);
    return (a < b) ? a : b;
  endfunction

  // Whole remainder if it fits; otherwise furthest line-aligned cut inside
  // the limit and the page, falling back to the raw bound if none exists.
  function automatic logic [AW:0] cut_point(input logic [AW:0] c,
                                            input logic [AW:0] t,
                                            input lim_t lim,
                                            input pmask_t mask);
    logic [AW:0] bound;
    logic [AW:0] aligned;
    bound = xmin(c + XW'(lim), page_end(c));
    if (t <= bound) return t;
    aligned = bound & ~XW'(mask);
    if (aligned > c) return aligned;
    return bound;
  endfunction

  assign nxt_end    = cut_point(cur, tot_end, cfg.limit, cfg.line_mask);
  assign chunk_len  = lim_t'(nxt_end - cur);
  assign chunk_last = (nxt_end == tot_end);

endmodule

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
  import dma_split_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_addr,
  input  logic [XLEN_W-1:0] in_len,
  input  logic              out_ready,
  input  logic [AW:0]       nxt_end,
  input  logic              chunk_last,
  output logic              busy,
  output logic              xfer_accept,
  output logic              zero_reject,
  output logic              chunk_fire,
  output logic [AW:0]       cur,
  output logic [AW:0]       tot_end,
  output logic              err_q
);

  localparam int XW = AW + 1;

  assign xfer_accept = in_valid && !busy;
  assign zero_reject = xfer_accept && (in_len == '0);
  assign chunk_fire  = busy && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur     <= '0;
      tot_end <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= zero_reject;
      if (xfer_accept && !zero_reject) begin
        busy    <= 1'b1;
        cur     <= {1'b0, in_addr};
        tot_end <= {1'b0, in_addr} + XW'(in_len);
      end else if (chunk_fire) begin
        cur <= nxt_end;
        if (chunk_last) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter
  import dma_split_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [15:0]       in_len,
  input  logic              in_write,
  input  logic              cfg_mps_sel,
  input  logic [12:0]       cfg_rd_max,
  input  logic [12:0]       cfg_cap,
  input  logic [1:0]        cfg_line_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [12:0]       out_len,
  output logic              out_write,
  output logic              out_last,
  output logic              err_zero_len
);

  logic        busy;
  logic        xfer_accept;
  logic        zero_reject;
  logic        chunk_fire;
  logic [AW:0] cur;
  logic [AW:0] tot_end;
  logic [AW:0] nxt_end;
  logic        chunk_last;
  lim_t        chunk_len;
  xfer_cfg_t   cfg_q;

  dma_split_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (xfer_accept && !zero_reject),
    .write     (in_write),
    .mps_sel   (cfg_mps_sel),
    .rd_max    (cfg_rd_max),
    .cap       (cfg_cap),
    .line_code (cfg_line_code),
    .cfg_q     (cfg_q)
  );

  dma_split_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .in_len      (in_len),
    .out_ready   (out_ready),
    .nxt_end     (nxt_end),
    .chunk_last  (chunk_last),
    .busy        (busy),
    .xfer_accept (xfer_accept),
    .zero_reject (zero_reject),
    .chunk_fire  (chunk_fire),
    .cur         (cur),
    .tot_end     (tot_end),
    .err_q       (err_zero_len)
  );

  dma_split_chunk_calc #(.AW(AW)) u_calc (
    .cur        (cur),
    .tot_end    (tot_end),
    .cfg        (cfg_q),
    .nxt_end    (nxt_end),
    .chunk_len  (chunk_len),
    .chunk_last (chunk_last)
  );

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_addr  = cur[AW-1:0];
  assign out_len   = chunk_len;
  assign out_write = cfg_q.write;
  assign out_last  = busy && chunk_last;

endmodule

// File: rtl/dma_req_splitter_chk.sv
module dma_req_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [15:0]   in_len,
  input logic          in_write,
  input logic          cfg_mps_sel,
  input logic [12:0]   cfg_rd_max,
  input logic [12:0]   cfg_cap,
  input logic [1:0]    cfg_line_code,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [12:0]   out_len,
  input logic          out_write,
  input logic          out_last,
  input logic          err_zero_len
);

  logic        wr_q;
  logic        mps_q;
  logic [12:0] rd_q;
  logic [12:0] cap_q;
  logic [1:0]  code_q;
  logic [13:0] line_bytes;
  logic [13:0] dir_lim;
  logic [13:0] eff_lim;
  logic [13:0] page_span;
  logic [AW-1:0] end_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0; mps_q <= 1'b0; rd_q <= '0; cap_q <= '0; code_q <= '0;
    end else if (in_valid && in_ready && in_len != 16'd0) begin
      wr_q <= in_write; mps_q <= cfg_mps_sel; rd_q <= cfg_rd_max;
      cap_q <= cfg_cap; code_q <= cfg_line_code;
    end
  end

  assign line_bytes = 14'd16 << code_q;
  assign dir_lim    = wr_q ? (mps_q ? 14'd256 : 14'd128) : {1'b0, rd_q};
  assign eff_lim    = (dir_lim < {1'b0, cap_q}) ? dir_lim : {1'b0, cap_q};
  assign page_span  = {2'b00, out_addr[11:0]} + {1'b0, out_len};
  assign end_addr   = out_addr + AW'(out_len);

  // R2
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> page_span <= 14'd4096);

  // R3
  wr_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_write) |-> out_len <= (mps_q ? 13'd256 : 13'd128));

  // R4
  rd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_write && rd_q != 13'd0) |-> out_len <= rd_q);

  // R5
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_q != 13'd0) |-> out_len <= cap_q);

  // R7
  split_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && eff_lim >= line_bytes && cap_q != 13'd0 && (wr_q || rd_q != 13'd0))
      |-> (end_addr[11:0] & (line_bytes[11:0] - 12'd1)) == 12'd0);

  // R8
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_addr == $past(end_addr)));

  // R8
  nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != 13'd0 && out_write == wr_q));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_last)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_len |-> (!out_valid && $past(in_valid && in_ready && in_len == 16'd0)));

endmodule

bind dma_req_splitter dma_req_splitter_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_len        (in_len),
  .in_write      (in_write),
  .cfg_mps_sel   (cfg_mps_sel),
  .cfg_rd_max    (cfg_rd_max),
  .cfg_cap       (cfg_cap),
  .cfg_line_code (cfg_line_code),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_len       (out_len),
  .out_write     (out_write),
  .out_last      (out_last),
  .err_zero_len  (err_zero_len)
);

// File: tb/dma_req_splitter_tb_top.sv
module dma_req_splitter_tb_top;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        wr;
    logic        mps;
    logic [12:0] rd;
    logic [12:0] cap;
    logic [1:0]  code;
    logic [7:0]  cnt;
    logic [12:0] first;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 16'd128,   1'b1, 1'b0, 13'd512,  13'd4096, 2'd2, 8'd1,  13'd128},
    '{32'h1010, 16'd100,   1'b1, 1'b0, 13'd512,  13'd4096, 2'd2, 8'd1,  13'd100},
    '{32'h1010, 16'd200,   1'b1, 1'b0, 13'd512,  13'd4096, 2'd2, 8'd2,  13'd112},
    '{32'h1FC0, 16'd128,   1'b0, 1'b0, 13'd512,  13'd4096, 2'd2, 8'd2,  13'd64},
    '{32'h0FF0, 16'd32,    1'b0, 1'b1, 13'd512,  13'd4096, 2'd2, 8'd2,  13'd16},
    '{32'h0100, 16'd1024,  1'b0, 1'b1, 13'd512,  13'd256,  2'd2, 8'd4,  13'd256},
    '{32'h2008, 16'd600,   1'b1, 1'b1, 13'd4096, 13'd4096, 2'd3, 8'd3,  13'd248},
    '{32'h0000, 16'd65535, 1'b0, 1'b0, 13'd4096, 13'd4096, 2'd0, 8'd16, 13'd4096}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [15:0] in_len = '0;
  logic        in_write = 1'b0;
  logic        cfg_mps_sel = 1'b0;
  logic [12:0] cfg_rd_max = 13'd512;
  logic [12:0] cfg_cap = 13'd4096;
  logic [1:0]  cfg_line_code = 2'd2;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [12:0] out_len;
  logic        out_write;
  logic        out_last;
  logic        err_zero_len;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_req_splitter #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_write(in_write),
    .cfg_mps_sel(cfg_mps_sel), .cfg_rd_max(cfg_rd_max), .cfg_cap(cfg_cap),
    .cfg_line_code(cfg_line_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_len(out_len), .out_write(out_write),
    .out_last(out_last), .err_zero_len(err_zero_len)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side restatement: room left in page and limit, then trim to a line.
  function automatic longint model_len(input longint cur, input longint tot,
                                       input longint lim, input longint line);
    longint rem, room, take, stop;
    rem  = tot - cur;
    room = 4096 - (cur % 4096);
    take = (lim < room) ? lim : room;
    if (rem <= take) return rem;
    stop = cur + take;
    stop = stop - (stop % line);
    if (stop > cur) return stop - cur;
    return take;
  endfunction

  task automatic run_vec(input vec_t v, input bit stall);
    longint cur, tot, lim, dir, line, el;
    int n;
    longint first_seen;
    dir  = v.wr ? (v.mps ? 256 : 128) : longint'(v.rd);
    lim  = (dir < longint'(v.cap)) ? dir : longint'(v.cap);
    if (lim > 4096) lim = 4096;
    line = 16 << v.code;
    @(negedge clk);
    in_addr = v.addr; in_len = v.len; in_write = v.wr;
    cfg_mps_sel = v.mps; cfg_rd_max = v.rd; cfg_cap = v.cap; cfg_line_code = v.code;
    in_valid = 1'b1;
    chk(in_ready === 1'b1, "R9 idle ready", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    // R11: scramble configuration right after acceptance
    cfg_mps_sel = ~v.mps; cfg_rd_max = 13'd16; cfg_cap = 13'd32; cfg_line_code = 2'd0;
    chk(in_ready === 1'b0, "R9 busy", longint'(in_ready), 0);
    cur = longint'(v.addr);
    tot = cur + longint'(v.len);
    n = 0;
    first_seen = -1;
    while (cur < tot && n < 40) begin
      el = model_len(cur, tot, lim, line);
      if (first_seen < 0) first_seen = longint'(out_len);
      chk(out_valid === 1'b1, "R8 valid", longint'(out_valid), 1);
      chk(longint'(out_addr) == cur, "R8 addr", longint'(out_addr), cur);
      chk(longint'(out_len) == el, "R7 R11 len", longint'(out_len), el);
      chk(out_write === v.wr, "R8 dir", longint'(out_write), longint'(v.wr));
      chk(out_last === ((cur + el) == tot), "R8 last", longint'(out_last), longint'((cur + el) == tot));
      chk((out_addr[11:0] + out_len) <= 4096, "R2 page", longint'(out_addr[11:0]) + longint'(out_len), 4096);
      if (v.wr) chk(longint'(out_len) <= dir, "R3 payload", longint'(out_len), dir);
      else      chk(longint'(out_len) <= dir, "R4 read size", longint'(out_len), dir);
      chk(longint'(out_len) <= longint'(v.cap), "R5 cap", longint'(out_len), longint'(v.cap));
      if (stall) begin
        @(negedge clk);
        chk(out_valid === 1'b1 && longint'(out_addr) == cur && longint'(out_len) == el,
            "R9 stall hold", longint'(out_addr), cur);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      cur += el;
      n++;
    end
    chk(out_valid === 1'b0, "R8 no extra", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R9 ready again", longint'(in_ready), 1);
    chk(n == int'(v.cnt), "R6 R7 count", n, longint'(v.cnt));
    chk(first_seen == longint'(v.first), "R6 R7 first len", first_seen, longint'(v.first));
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid === 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready", longint'(in_ready), 1);
    chk(err_zero_len === 1'b0, "R1 err", longint'(err_zero_len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release", longint'(out_valid), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 2) == 1);

    // R10: zero-length transfer
    @(negedge clk);
    in_addr = 32'h3000; in_len = 16'd0; in_write = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(err_zero_len === 1'b1, "R10 pulse", longint'(err_zero_len), 1);
    chk(out_valid === 1'b0, "R10 silent", longint'(out_valid), 0);
    @(negedge clk);
    chk(err_zero_len === 1'b0, "R10 one cycle", longint'(err_zero_len), 0);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 idle", longint'(out_valid), 0);

    // R6: read spanning lines but fitting whole, after a reject
    run_vec('{32'h5020, 16'd300, 1'b0, 1'b0, 13'd512, 13'd4096, 2'd1, 8'd1, 13'd300}, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule